// File: doc/BRIEF.md
# Half-Bridge Dead-Band Delay Generator

This block turns a single PWM waveform into the two gate drives of a half-bridge. The high-side drive follows the PWM when it is high and the low-side drive follows it when it is low. Whenever the PWM changes level, the drive that was on is released at the very next clock edge. The drive that is about to come on waits for a programmable dead time, so the two switches cannot conduct together while one of them is still turning off.

The dead time is given as a 7-bit tick count. One tick is four clocks, which matches an instruction-cycle time base. Only turn-on is delayed; turn-off is never delayed. The tick prescaler restarts on every PWM edge, so the dead time is fixed and does not depend on phase. An enable input gates the whole path. Period, duty-cycle generation and fault shutdown belong to neighbouring logic.

Top module: `hb_deadband`

## Requirements
- R1: While reset is asserted, or while `en` is low, both `drv_hi` and `drv_lo` are 0. Dropping `en` forces both to 0 at the next clock edge.
- R2: The outputs are complementary in sense. `drv_hi` (value 1) can only become active after `pwm_in` has been sampled at 1, and `drv_lo` (value 1) can only become active after `pwm_in` has been sampled at 0.
- R3: At the first clock edge that samples a new `pwm_in` level (edge 1), both outputs are 0. Turn-off is never delayed.
- R4: With delay value D captured at edge 1, the drive selected by the new level becomes 1 at edge 4*D+2 and stays 0 before it. This is D ticks of four clocks, plus one edge for the decision.
- R5: With D = 0, the selected drive becomes active at edge 2, with no extra tick.
- R6: The full range works. D = 127 gives activation at edge 510.
- R7: `drv_hi` and `drv_lo` are never 1 in the same cycle.
- R8: A `pwm_in` edge that arrives while an activation is still pending cancels that activation, which never happens. The new edge starts its own delay, measured from itself.
- R9: `dly_cnt` is captured only at the edge that detects a `pwm_in` change. Changing it during the wait does not alter the pending delay.
- R10: When `en` rises, the current `pwm_in` level is treated as a fresh edge. Its drive becomes active at edge 4*D+2, counted from the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the dead-band path; low forces both drives off |
| pwm_in | input | 1 | PWM waveform to be split |
| dly_cnt | input | 7 | Dead time in ticks of four clocks |
| drv_hi | output | 1 | High-side switch drive, active high |
| drv_lo | output | 1 | Low-side switch drive, active high |

## Verification
A table of alternating rising and falling PWM edges is paired with delays of 0, 1, 2, 3, 5, 64 and 127 ticks. This separates an off-by-one in the tick count from an error in prescaler alignment, and confirms that each edge direction selects the correct drive. Directed runs then use a PWM that flips back mid-delay, which shows that the abandoned activation is cancelled rather than merely deferred. They also change the delay value mid-wait, which shows it is captured only at the edge. Finally, they toggle the enable, which shows both that the drives are forced off and that re-enabling counts as a fresh edge.

// File: rtl/hb_deadband.sv
module hb_deadband #(
  parameter int DW   = 7,
  parameter int TICK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pwm_in,
  input  logic [DW-1:0] dly_cnt,
  output logic          drv_hi,
  output logic          drv_lo
);
  localparam int PW = (TICK > 2) ? $clog2(TICK) : 1;

  logic [PW-1:0] pre;
  logic [DW-1:0] rem;
  logic          pend, tgt, armed, pwm_q;

  wire evt  = en && (!armed || (pwm_in != pwm_q));
  wire tick = (pre == PW'(TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; rem <= '0; pend <= 1'b0; tgt <= 1'b0;
      armed <= 1'b0; pwm_q <= 1'b0; drv_hi <= 1'b0; drv_lo <= 1'b0;
    end else if (!en) begin
      pre <= '0; pend <= 1'b0; armed <= 1'b0;
      pwm_q <= pwm_in; drv_hi <= 1'b0; drv_lo <= 1'b0;
    end else begin
      armed <= 1'b1;
      pwm_q <= pwm_in;
      if (evt) begin
        drv_hi <= 1'b0;
        drv_lo <= 1'b0;
        pend   <= 1'b1;
        tgt    <= pwm_in;
        rem    <= dly_cnt;
        pre    <= '0;
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (pend) begin
          if (rem == '0) begin
            pend   <= 1'b0;
            drv_hi <= tgt;
            drv_lo <= !tgt;
          end else if (tick) begin
            rem <= rem - DW'(1);
          end
        end
      end
    end
  end

  p_never_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drv_hi && !drv_lo));

  p_fast_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && armed && pwm_in != pwm_q) |=> (!drv_hi && !drv_lo));

  p_hi_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> $past(pwm_in));

  p_lo_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> !$past(pwm_in));
endmodule

// File: tb/hb_deadband_tb_top.sv
module hb_deadband_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic pwm_in = 1'b0;
  logic [6:0] dly_cnt = '0;
  logic drv_hi, drv_lo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  hb_deadband dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm_in),
    .dly_cnt(dly_cnt), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  localparam logic [7:0] VEC [8] = '{
    {1'b1, 7'd0}, {1'b0, 7'd0}, {1'b1, 7'd1}, {1'b0, 7'd3},
    {1'b1, 7'd127}, {1'b0, 7'd5}, {1'b1, 7'd2}, {1'b0, 7'd64}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Applies en/pwm/dly at a negedge and counts edges until the selected drive rises.
  // chg_k > 0 rewrites dly_cnt to newd after that many edges; stop_k > 0 ends early.
  task automatic edge_run(input logic en_v, input logic lvl, input logic [6:0] d,
                          input int chg_k, input logic [6:0] newd, input int stop_k,
                          input int exp, input string req);
    int found = 0;
    bit clash = 0, wrong = 0;
    @(negedge clk);
    en = en_v; pwm_in = lvl; dly_cnt = d;
    for (int k = 1; k <= 600; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) chk(!drv_hi && !drv_lo, "R3", {drv_hi, drv_lo}, 0);
      if (drv_hi && drv_lo) clash = 1;
      if (lvl ? drv_lo : drv_hi) wrong = 1;
      if (k == chg_k) dly_cnt = newd;
      if ((lvl ? drv_hi : drv_lo) && found == 0) found = k;
      if (found != 0 || (stop_k > 0 && k == stop_k)) break;
    end
    chk(!clash, "R7", clash, 0);
    chk(!wrong, "R2", wrong, 0);
    chk(found == exp, req, found, exp);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!drv_hi && !drv_lo, "R1", {drv_hi, drv_lo}, 0);
    rst_n = 1'b1;
    pwm_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(!drv_hi && !drv_lo, "R1", {drv_hi, drv_lo}, 0);
    @(negedge clk);
    en = 1'b1; pwm_in = 1'b0;
    repeat (10) @(negedge clk);

    // Table walk: R4 timing, R5 at D=0, R6 at D=127.
    foreach (VEC[i]) begin
      logic [6:0] dv = VEC[i][6:0];
      edge_run(1'b1, VEC[i][7], dv, 0, 7'd0, 0, 4 * int'(dv) + 2,
               dv == 0 ? "R5" : (dv == 127 ? "R6" : "R4"));
    end

    // R8: pwm flips back mid-delay; abandoned high-side never rises.
    edge_run(1'b1, 1'b1, 7'd10, 0, 7'd0, 8, 0, "R8");
    edge_run(1'b1, 1'b0, 7'd2, 0, 7'd0, 0, 10, "R8");

    // R9: delay changed mid-wait is ignored.
    edge_run(1'b1, 1'b1, 7'd5, 3, 7'd0, 0, 22, "R9");
    edge_run(1'b1, 1'b0, 7'd0, 0, 7'd0, 0, 2, "R9");

    // R1: disable forces off, pwm activity ignored.
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!drv_hi && !drv_lo, "R1", {drv_hi, drv_lo}, 0);
    for (int j = 0; j < 6; j++) begin
      pwm_in = ~pwm_in;
      repeat (3) @(negedge clk);
      chk(!drv_hi && !drv_lo, "R1", {drv_hi, drv_lo}, 0);
    end

    // R10: enable rise with pwm held high acts as an edge.
    pwm_in = 1'b1;
    @(negedge clk);
    edge_run(1'b1, 1'b1, 7'd3, 0, 7'd0, 0, 14, "R10");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule